// File: doc/BRIEF.md
# Stereo PDM Microphone Receiver

This block generates the bit clock for a pair of pulse-density-modulated digital microphones that share a single data wire. It also samples that wire once for each channel in every microphone clock period. The two microphones drive the wire in opposite halves of the clock period, so the block latches the left and right bits at two separate points in the period. Software picks those points from four placements. Two placements use the clock edges. The other two use the middle of the high time and the middle of the low time.

The microphone clock comes from the master clock through one of four integer dividers, chosen by a 2-bit rate field. The clock is high for the first half of each period and low for the second half. A new rate or a new latch placement takes effect only at a period boundary, so the output clock never shows a shortened pulse. At the end of each period the block presents the left and right bits as a parallel pair with a one-cycle valid strobe. In mono mode the right output repeats the left bit. The decimation filters that follow the block consume this bit pair stream.

Top module: `pdm_mic_rx`

## Requirements
- R1: For rate code 0, 1, 2 and 3, the microphone clock period is 6, 8, 12 and 24 master cycles. The clock is high for the first half of each period and low for the second half.
- R2: While reset is active and in the first cycle after release, the microphone clock, the valid strobe and both data outputs are 0. The microphone clock goes high on the first master edge after release.
- R3: The rate and phase inputs are taken only on the master edge where a new microphone clock period begins, so every high and low time is a full half period.
- R4: Phase code 0 latches left one master cycle after the clock rises and right one master cycle after it falls.
- R5: Phase code 1 latches left at the middle of the high time and right at the middle of the low time. With H the half period, these are master edges H/2+1 and H+H/2+1 after the rise.
- R6: Phase code 2 latches left one master cycle after the clock falls and right one master cycle after it rises.
- R7: Phase code 3 latches left at the middle of the low time and right at the middle of the high time.
- R8: The mono input is sampled with each result. At 1 the right output equals the left bit. At 0 the right output carries the right bit.
- R9: The valid strobe is high for exactly one master cycle per microphone period, starting on the edge where the clock rises. It carries the bits of the period that just ended. No strobe follows the partial period at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_rate_i | input | 2 | Microphone clock divider select |
| cfg_phase_i | input | 2 | Left/right latch placement select |
| cfg_mono_i | input | 1 | Copy left bit to right output |
| mic_dat_i | input | 1 | Shared microphone data line |
| mic_clk_o | output | 1 | Microphone bit clock |
| pcm_left_o | output | 1 | Latched left bit |
| pcm_right_o | output | 1 | Latched right bit, or left in mono mode |
| pcm_valid_o | output | 1 | One-cycle strobe for a new bit pair |

## Verification
The data line carries a pseudo-random value that changes every master cycle. A latch point that is one cycle early or late, or a left/right swap within one phase code, therefore shows up as wrong bits. Rate and phase change at instants that do not line up with a period boundary. A design that applied them at once would show a shortened high or low time and a misplaced strobe. Mono mode is toggled between runs, so a design that kept stereo, or copied the wrong channel, would give a right output that disagrees with the expected value. A second reset in the middle of a period makes sure no stray strobe comes out of the partial reset period.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;
  typedef enum logic [1:0] {
    PH_RISE_FALL = 2'd0,
    PH_MIDH_MIDL = 2'd1,
    PH_FALL_RISE = 2'd2,
    PH_MIDL_MIDH = 2'd3
  } latch_phase_e;

  typedef logic [1:0] rate_sel_t;

  localparam rate_sel_t RATE_RESET = 2'd2;
endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
  import pdm_rx_pkg::*;
#(
  parameter int unsigned DIV0 = 6,
  parameter int unsigned DIV1 = 8,
  parameter int unsigned DIV2 = 12,
  parameter int unsigned DIV3 = 24,
  parameter int unsigned CW   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_i,
  input  logic [1:0] phase_i,
  output logic       mic_clk_o,
  output logic       smp_l_o,
  output logic       smp_r_o,
  output logic       end_o
);

  function automatic logic [CW-1:0] div_of(input rate_sel_t r);
    case (r)
      2'd0:    div_of = CW'(DIV0);
      2'd1:    div_of = CW'(DIV1);
      2'd2:    div_of = CW'(DIV2);
      default: div_of = CW'(DIV3);
    endcase
  endfunction

  logic [CW-1:0] cnt_q, cnt_d;
  rate_sel_t     rate_q, rate_d;
  latch_phase_e  phase_q, phase_d;
  logic          mic_q, mic_d;
  logic [CW-1:0] div_cur, half_cur, quart_cur, div_nxt;
  logic [CW-1:0] pt_l, pt_r;
  logic          last;

  always_comb begin
    div_cur   = div_of(rate_q);
    half_cur  = div_cur >> 1;
    quart_cur = half_cur >> 1;
    last      = (cnt_q == div_cur - CW'(1));
    case (phase_q)
      PH_RISE_FALL: begin pt_l = '0;                   pt_r = half_cur;             end
      PH_MIDH_MIDL: begin pt_l = quart_cur;            pt_r = half_cur + quart_cur; end
      PH_FALL_RISE: begin pt_l = half_cur;             pt_r = '0;                   end
      default:      begin pt_l = half_cur + quart_cur; pt_r = quart_cur;            end
    endcase
  end

  always_comb begin
    rate_d  = rate_q;
    phase_d = phase_q;
    cnt_d   = cnt_q + CW'(1);
    if (last) begin
      cnt_d   = '0;
      rate_d  = rate_i;
      phase_d = latch_phase_e'(phase_i);
    end
    div_nxt = div_of(rate_d);
    mic_d   = (cnt_d < (div_nxt >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CW'(DIV2 - 1);
      rate_q  <= RATE_RESET;
      phase_q <= PH_RISE_FALL;
      mic_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rate_q  <= rate_d;
      phase_q <= phase_d;
      mic_q   <= mic_d;
    end
  end

  assign mic_clk_o = mic_q;
  assign smp_l_o   = (cnt_q == pt_l);
  assign smp_r_o   = (cnt_q == pt_r);
  assign end_o     = last;

  p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_o |=> ($stable(rate_q) && $stable(phase_q)));

  p_high_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mic_q) |=> mic_q ##1 mic_q);

  p_low_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mic_q) |=> !mic_q ##1 !mic_q);

  p_points_apart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_l_o && smp_r_o));

endmodule

// File: rtl/pdm_capture.sv
module pdm_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dat_i,
  input  logic smp_l_i,
  input  logic smp_r_i,
  input  logic end_i,
  input  logic mono_i,
  output logic left_o,
  output logic right_o,
  output logic valid_o
);

  logic lcap_q, lcap_d, rcap_q, rcap_d;
  logic out_l_q, out_l_d, out_r_q, out_r_d;
  logic vld_q, vld_d, primed_q, primed_d;

  always_comb begin
    lcap_d   = smp_l_i ? dat_i : lcap_q;
    rcap_d   = smp_r_i ? dat_i : rcap_q;
    out_l_d  = out_l_q;
    out_r_d  = out_r_q;
    vld_d    = 1'b0;
    primed_d = primed_q | end_i;
    if (end_i && primed_q) begin
      out_l_d = lcap_q;
      out_r_d = mono_i ? lcap_q : rcap_q;
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcap_q   <= 1'b0;
      rcap_q   <= 1'b0;
      out_l_q  <= 1'b0;
      out_r_q  <= 1'b0;
      vld_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lcap_q   <= lcap_d;
      rcap_q   <= rcap_d;
      out_l_q  <= out_l_d;
      out_r_q  <= out_r_d;
      vld_q    <= vld_d;
      primed_q <= primed_d;
    end
  end

  assign left_o  = out_l_q;
  assign right_o = out_r_q;
  assign valid_o = vld_q;

  p_mono_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mono_i)) |-> (right_o == left_o));

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_at_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(end_i));

endmodule

// File: rtl/pdm_mic_rx.sv
module pdm_mic_rx #(
  parameter int unsigned DIV0 = 6,
  parameter int unsigned DIV1 = 8,
  parameter int unsigned DIV2 = 12,
  parameter int unsigned DIV3 = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cfg_rate_i,
  input  logic [1:0] cfg_phase_i,
  input  logic       cfg_mono_i,
  input  logic       mic_dat_i,
  output logic       mic_clk_o,
  output logic       pcm_left_o,
  output logic       pcm_right_o,
  output logic       pcm_valid_o
);

  localparam int unsigned DMAX01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int unsigned DMAX23 = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int unsigned DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
  localparam int unsigned CW     = $clog2(DMAX + 1);

  logic smp_l, smp_r, per_end;

  pdm_clkgen #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .CW(CW)
  ) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_i    (cfg_rate_i),
    .phase_i   (cfg_phase_i),
    .mic_clk_o (mic_clk_o),
    .smp_l_o   (smp_l),
    .smp_r_o   (smp_r),
    .end_o     (per_end)
  );

  pdm_capture u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dat_i   (mic_dat_i),
    .smp_l_i (smp_l),
    .smp_r_i (smp_r),
    .end_i   (per_end),
    .mono_i  (cfg_mono_i),
    .left_o  (pcm_left_o),
    .right_o (pcm_right_o),
    .valid_o (pcm_valid_o)
  );

  p_strobe_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_valid_o |-> $rose(mic_clk_o));

endmodule

// File: tb/pdm_mic_rx_tb.sv
module pdm_mic_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate = 2'd2;
  logic [1:0] phase = 2'd0;
  logic       mono = 1'b0;
  logic       dat = 1'b0;
  logic       mic_clk, p_l, p_r, p_v;
  logic [15:0] lfsr = 16'hACE1;

  int vectors = 0;
  int errs = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pdm_mic_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_rate_i(rate), .cfg_phase_i(phase),
    .cfg_mono_i(mono), .mic_dat_i(dat), .mic_clk_o(mic_clk),
    .pcm_left_o(p_l), .pcm_right_o(p_r), .pcm_valid_o(p_v)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int div_of(input int r);
    case (r)
      0: return 6;
      1: return 8;
      2: return 12;
      default: return 24;
    endcase
  endfunction

  // behavioural reference model
  int m_pos, m_n, m_ph, m_l, m_r, m_ol, m_or, m_v, m_mic, m_primed, m_tagph, m_mono;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_n = 12; m_pos = 11; m_ph = 0; m_mic = 0; m_v = 0;
      m_l = 0; m_r = 0; m_ol = 0; m_or = 0; m_primed = 0;
    end else begin
      int h, q, lp, rp;
      h = m_n / 2; q = h / 2;
      case (m_ph)
        0: begin lp = 0;     rp = h;     end
        1: begin lp = q;     rp = h + q; end
        2: begin lp = h;     rp = 0;     end
        default: begin lp = h + q; rp = q; end
      endcase
      if (m_pos == lp) m_l = dat;
      if (m_pos == rp) m_r = dat;
      m_v = 0;
      if (m_pos == m_n - 1) begin
        if (m_primed != 0) begin
          m_v = 1; m_ol = m_l; m_or = mono ? m_l : m_r;
          m_tagph = m_ph; m_mono = mono;
        end
        m_primed = 1;
        m_pos = 0; m_n = div_of(rate); m_ph = phase;
      end else begin
        m_pos++;
      end
      m_mic = (m_pos < m_n / 2) ? 1 : 0;
    end
  end

  function automatic string ph_tag(input int p);
    case (p)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check("R1", mic_clk, m_mic);
      check("R9", p_v, m_v);
      if (m_v != 0) begin
        check(ph_tag(m_tagph), p_l, m_ol);
        check(m_mono != 0 ? "R8" : ph_tag(m_tagph), p_r, m_or);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dat = lfsr[0];
  end

  task automatic do_reset();
    @(posedge clk); cmp_en = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", mic_clk, 0);
    check("R2", p_v, 0);
    rst_n = 1'b1;
    #1;
    check("R2", mic_clk, 0);
    check("R2", p_v, 0);
    check("R2", p_l, 0);
    check("R2", p_r, 0);
    @(posedge clk); #1;
    check("R2", mic_clk, 1);
    cmp_en = 1'b1;
  endtask

  initial begin
    do_reset();
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        rate = r[1:0]; phase = p[1:0]; mono = ((r + p) % 3) == 1;
        repeat (70 + 3 * r + p) @(negedge clk);
      end
    end
    // R3: mid-period reconfiguration and a reset inside a period
    rate = 2'd3; phase = 2'd1; mono = 1'b0;
    repeat (37) @(negedge clk);
    rate = 2'd0; phase = 2'd3;
    repeat (29) @(negedge clk);
    do_reset();
    mono = 1'b1;
    repeat (60) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule